// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Detection and Turbo Current Control

This block compares two divided edge streams, one from the reference divider and one from the oscillator divider, using a digital three-state phase-frequency detector. It issues pump-up and pump-down commands to an external charge pump. A polarity bit sets which comparison result maps to which command, so a loop can use an oscillator whose frequency rises or falls with tune voltage.

Every comparison ends when both sides have seen their edge. The block measures how long one side was active alone during that comparison. A run of short comparisons raises a lock flag, and one long pulse drops it. A 3-bit current select tells the charge pump how much current to deliver. It carries the programmed 2-bit magnitude during tracking. While turbo is enabled and the loop has not yet locked, it carries a distinct high-current value instead. That fast-acquisition state is armed at reset and again by a restart strobe, which the register interface issues on every divider or control load.

All logic runs on an oversampling system clock. Both divided clocks pass through synchronizers before their rising edges are detected.

Top module: `pfd_lock_turbo`

## Requirements
- R1: A rising edge on a divided clock first shows on the pump outputs three system clock cycles after the cycle in which the input rose. The outputs stay idle in the cycle before that.
- R2: The side whose edge arrives first holds its pump output alone until the other edge arrives. Both outputs are then high for exactly one cycle, and both are low in the following cycle.
- R3: With `pol_i`=1, a reference edge drives `up_o` and an oscillator edge drives `dn_o`. With `pol_i`=0, the two mappings are swapped.
- R4: Edges arriving in the same cycle give one cycle with both outputs high, then idle. No one-sided pulse appears.
- R5: `lock_o` rises in the cycle after the 16th consecutive comparison whose one-sided width, in system clock cycles, is below `lock_win_i`.
- R6: While locked, `lock_o` falls in the cycle after a one-sided pulse has lasted `lock_win_i` cycles, even before that comparison ends.
- R7: `isel_o` uses two encodings. 3'b0cc means programmed magnitude cc, where 00 is the lowest and 11 the highest of four levels. 3'b100 means turbo current. No other value appears.
- R8: `isel_o` is 3'b100 while `turbo_en_i`=1, turbo is armed and `lock_o`=0. The first lock disarms turbo, and `isel_o` returns to the programmed code in that same cycle. It stays there if lock is later lost.
- R9: A one-cycle `restart_i` clears lock and the good-comparison count, with `lock_o` low the next cycle. It also re-arms turbo, so a fresh run of 16 good comparisons is needed to lock again.
- R10: After reset, `up_o`, `dn_o` and `lock_o` are low and turbo is armed.
- R11: With `turbo_en_i`=0, `isel_o` is always the programmed code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_div_i | input | 1 | Divided reference clock |
| vco_div_i | input | 1 | Divided oscillator clock |
| pol_i | input | 1 | Pump polarity: 1 maps the reference-leads case to up |
| turbo_en_i | input | 1 | Allows high current during acquisition |
| icp_code_i | input | 2 | Programmed pump magnitude code |
| restart_i | input | 1 | One-cycle strobe from a register load; re-arms acquisition |
| lock_win_i | input | WIN_W | Width limit, in system cycles, for a comparison to count as locked |
| up_o | output | 1 | Pump source command |
| dn_o | output | 1 | Pump sink command |
| lock_o | output | 1 | High while the loop is considered locked |
| isel_o | output | 3 | Current level select (3'b0cc programmed, 3'b100 turbo) |

## Verification
The assertions check four rules on every cycle:
- Both pump outputs always clear together after their shared high cycle.
- The current select never leaves its two legal encodings.
- Lock always coincides with the programmed code.
- Lock rises only right after a completed comparison, and a restart always removes it.

Only the bench scenarios can show the rest: the exact synchronizer latency, the polarity swap, the 16-comparison lock count, the mid-pulse unlock at the programmed width, and turbo staying off after a lock loss until a restart.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int ISEL_W = 3;
  localparam int CODE_W = 2;
  typedef logic [ISEL_W-1:0] isel_t;
  localparam isel_t ISEL_TURBO = 3'b100;

  typedef struct packed {
    logic ref_act;
    logic vco_act;
  } pfd_state_t;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q, chain_n;
  logic              last_q;

  always_comb begin
    chain_n[0] = d_i;
    for (int i = 1; i < STAGES; i++) chain_n[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_n;
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise_i,
  input  logic vco_rise_i,
  input  logic pol_i,
  output logic up_o,
  output logic dn_o,
  output logic cmp_done_o,
  output logic one_sided_o
);
  pfd_state_t st_q, st_n;

  always_comb begin
    st_n = st_q;
    if (st_q.ref_act && st_q.vco_act) begin
      st_n = '0;
    end else begin
      st_n.ref_act = st_q.ref_act | ref_rise_i;
      st_n.vco_act = st_q.vco_act | vco_rise_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_n;
  end

  assign up_o        = pol_i ? st_q.ref_act : st_q.vco_act;
  assign dn_o        = pol_i ? st_q.vco_act : st_q.ref_act;
  assign cmp_done_o  = st_q.ref_act & st_q.vco_act;
  assign one_sided_o = st_q.ref_act ^ st_q.vco_act;
endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det #(
  parameter int WIN_W    = 8,
  parameter int LOCK_CNT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_done_i,
  input  logic             one_sided_i,
  input  logic             restart_i,
  input  logic [WIN_W-1:0] win_i,
  output logic             lock_o
);
  localparam int GCNT_W = $clog2(LOCK_CNT + 1);
  localparam logic [GCNT_W-1:0] GMAX  = GCNT_W'(LOCK_CNT);
  localparam logic [GCNT_W-1:0] GLAST = GCNT_W'(LOCK_CNT - 1);
  localparam logic [WIN_W-1:0]  WMAX  = '1;

  logic [WIN_W-1:0]  wcnt_q, wcnt_n;
  logic [GCNT_W-1:0] gcnt_q, gcnt_n;
  logic              lock_q, lock_n;
  logic              overrun;

  always_comb begin
    wcnt_n  = wcnt_q;
    gcnt_n  = gcnt_q;
    lock_n  = lock_q;
    overrun = (wcnt_q >= win_i);
    if (restart_i) begin
      wcnt_n = '0;
      gcnt_n = '0;
      lock_n = 1'b0;
    end else begin
      if (cmp_done_i)                         wcnt_n = '0;
      else if (one_sided_i && wcnt_q != WMAX) wcnt_n = wcnt_q + 1'b1;

      if (overrun) begin
        gcnt_n = '0;
        lock_n = 1'b0;
      end else if (cmp_done_i) begin
        if (gcnt_q != GMAX)  gcnt_n = gcnt_q + 1'b1;
        if (gcnt_q >= GLAST) lock_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      gcnt_q <= '0;
      lock_q <= 1'b0;
    end else begin
      wcnt_q <= wcnt_n;
      gcnt_q <= gcnt_n;
      lock_q <= lock_n;
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/pfd_isel_ctrl.sv
module pfd_isel_ctrl
  import pfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              turbo_en_i,
  input  logic              restart_i,
  input  logic              lock_i,
  input  logic [CODE_W-1:0] code_i,
  output isel_t             isel_o
);
  logic turbo_q, turbo_n;

  always_comb begin
    turbo_n = turbo_q;
    if (restart_i)   turbo_n = 1'b1;
    else if (lock_i) turbo_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) turbo_q <= 1'b1;
    else        turbo_q <= turbo_n;
  end

  assign isel_o = (turbo_en_i && turbo_q && !lock_i) ? ISEL_TURBO
                                                     : {1'b0, code_i};
endmodule

// File: rtl/pfd_lock_turbo.sv
module pfd_lock_turbo
  import pfd_pkg::*;
#(
  parameter int WIN_W       = 8,
  parameter int LOCK_CNT    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_div_i,
  input  logic             vco_div_i,
  input  logic             pol_i,
  input  logic             turbo_en_i,
  input  logic [1:0]       icp_code_i,
  input  logic             restart_i,
  input  logic [WIN_W-1:0] lock_win_i,
  output logic             up_o,
  output logic             dn_o,
  output logic             lock_o,
  output logic [2:0]       isel_o
);
  localparam int N_CH = 2;

  logic            rst_meta_q, rst_sync_n;
  logic [N_CH-1:0] div_in, div_rise;
  logic            cmp_done, one_sided;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign div_in = {vco_div_i, ref_div_i};

  for (genvar g = 0; g < N_CH; g++) begin : g_sync
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .d_i    (div_in[g]),
      .rise_o (div_rise[g])
    );
  end

  pfd_core u_core (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ref_rise_i  (div_rise[0]),
    .vco_rise_i  (div_rise[1]),
    .pol_i       (pol_i),
    .up_o        (up_o),
    .dn_o        (dn_o),
    .cmp_done_o  (cmp_done),
    .one_sided_o (one_sided)
  );

  pfd_lock_det #(.WIN_W(WIN_W), .LOCK_CNT(LOCK_CNT)) u_lock (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cmp_done_i  (cmp_done),
    .one_sided_i (one_sided),
    .restart_i   (restart_i),
    .win_i       (lock_win_i),
    .lock_o      (lock_o)
  );

  pfd_isel_ctrl u_isel (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .turbo_en_i (turbo_en_i),
    .restart_i  (restart_i),
    .lock_i     (lock_o),
    .code_i     (icp_code_i),
    .isel_o     (isel_o)
  );
endmodule

// File: rtl/pfd_lock_turbo_chk.sv
module pfd_lock_turbo_chk (
  input logic       clk,
  input logic       rst_ni,
  input logic       up_o,
  input logic       dn_o,
  input logic       lock_o,
  input logic [2:0] isel_o,
  input logic [1:0] icp_code_i,
  input logic       turbo_en_i,
  input logic       restart_i
);
  // R2
  both_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (up_o && dn_o) |=> (!up_o && !dn_o));

  // R7
  isel_legal_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    isel_o[2] |-> (isel_o[1:0] == 2'b00 && turbo_en_i));

  // R8
  locked_prog_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    lock_o |-> (isel_o == {1'b0, icp_code_i}));

  // R9
  restart_unlock_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    restart_i |=> !lock_o);

  // R5
  lock_after_cmp_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(up_o && dn_o));
endmodule

bind pfd_lock_turbo pfd_lock_turbo_chk u_chk (
  .clk        (clk),
  .rst_ni     (rst_sync_n),
  .up_o       (up_o),
  .dn_o       (dn_o),
  .lock_o     (lock_o),
  .isel_o     (isel_o),
  .icp_code_i (icp_code_i),
  .turbo_en_i (turbo_en_i),
  .restart_i  (restart_i)
);

// File: tb/tb_pfd_lock_turbo.sv
module tb_pfd_lock_turbo;
  localparam int WIN_W = 8;
  localparam int S_UP = 0, S_DN = 1, S_LOCK = 2, S_ISEL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_div = 1'b0, vco_div = 1'b0, pol = 1'b1, ten = 1'b1, restart = 1'b0;
  logic [1:0] code = 2'b10;
  logic [WIN_W-1:0] win = 8'd8;
  logic up, dn, lock;
  logic [2:0] isel;

  always #10 clk = ~clk;

  pfd_lock_turbo dut (
    .clk(clk), .rst_n(rst_n), .ref_div_i(ref_div), .vco_div_i(vco_div),
    .pol_i(pol), .turbo_en_i(ten), .icp_code_i(code), .restart_i(restart),
    .lock_win_i(win), .up_o(up), .dn_o(dn), .lock_o(lock), .isel_o(isel)
  );

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    int    sig;
    int    val;
    string tag;
  } exp_t;
  exp_t sb[$];

  // model state
  int gc = 0;
  bit lockm = 1'b0;
  bit tm = 1'b1;

  task automatic push(int at, int sig, int val, string tag);
    exp_t e;
    int i;
    e.at = at; e.sig = sig; e.val = val; e.tag = tag;
    i = sb.size();
    while (i > 0 && sb[i-1].at > at) i--;
    sb.insert(i, e);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor
  always @(negedge clk) begin
    exp_t e;
    int act;
    string nm;
    #1;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      e = sb.pop_front();
      case (e.sig)
        S_UP:    begin act = int'(up);   nm = "up";   end
        S_DN:    begin act = int'(dn);   nm = "dn";   end
        S_LOCK:  begin act = int'(lock); nm = "lock"; end
        default: begin act = int'(isel); nm = "isel"; end
      endcase
      checks++;
      if (e.at != cyc) begin
        fails++;
        $display("FAIL %s: %s check at cycle %0d missed (actual cycle %0d, expected %0d)",
                 e.tag, nm, e.at, cyc, e.at);
      end else if (act != e.val) begin
        fails++;
        $display("FAIL %s: %s at cycle %0d actual %0d expected %0d",
                 e.tag, nm, cyc, act, e.val);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc == 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected completion earlier", cyc);
      report();
    end
  end

  function automatic int isel_exp();
    return (ten && tm && !lockm) ? 4 : int'(code);
  endfunction

  function automatic string isel_tag();
    if (!ten)               return "R11";
    else if (tm && !lockm)  return "R8";
    else                    return "R7";
  endfunction

  // one comparison: reference rises at offset ro, oscillator at vo
  task automatic compare(int ro, int vo);
    int b, lo, hi, f, e, d;
    bit ref_lead, up_lead;
    b  = cyc;
    lo = (ro < vo) ? ro : vo;
    hi = (ro < vo) ? vo : ro;
    f  = b + lo + 3;
    e  = b + hi + 3;
    d  = hi - lo;
    push(f - 1, S_UP, 0, "R1");
    push(f - 1, S_DN, 0, "R1");
    if (d != 0) begin
      ref_lead = (ro < vo);
      up_lead  = (ref_lead == pol);
      push(f, S_UP, up_lead ? 1 : 0, "R3");
      push(f, S_DN, up_lead ? 0 : 1, "R3");
      push(e, S_UP, 1, "R2");
      push(e, S_DN, 1, "R2");
      push(e + 1, S_UP, 0, "R2");
      push(e + 1, S_DN, 0, "R2");
    end else begin
      push(f, S_UP, 1, "R4");
      push(f, S_DN, 1, "R4");
      push(f + 1, S_UP, 0, "R4");
      push(f + 1, S_DN, 0, "R4");
    end
    if (d < int'(win)) begin
      if (gc < 16) gc++;
      if (gc == 16 && !lockm) begin
        push(e, S_LOCK, 0, "R5");
        push(e + 1, S_LOCK, 1, "R5");
        lockm = 1'b1;
        tm = 1'b0;
      end
    end else begin
      if (lockm) begin
        push(f + int'(win), S_LOCK, 1, "R6");
        push(f + int'(win) + 1, S_LOCK, 0, "R6");
      end
      lockm = 1'b0;
      gc = 0;
    end
    push(e + 2, S_LOCK, lockm ? 1 : 0, "R5");
    push(e + 1, S_ISEL, isel_exp(), isel_tag());
    for (int i = 0; i < 20; i++) begin
      ref_div = (i >= ro && i < 12);
      vco_div = (i >= vo && i < 12);
      @(negedge clk);
    end
  endtask

  task automatic do_restart();
    int b;
    b = cyc;
    lockm = 1'b0;
    gc = 0;
    tm = 1'b1;
    push(b + 1, S_LOCK, 0, "R9");
    push(b + 1, S_ISEL, ten ? 4 : int'(code), "R9");
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state, turbo armed
    push(cyc + 1, S_UP, 0, "R10");
    push(cyc + 1, S_DN, 0, "R10");
    push(cyc + 1, S_LOCK, 0, "R10");
    push(cyc + 1, S_ISEL, 4, "R10");
    @(negedge clk);
    @(negedge clk);

    // acquisition in turbo, lock after 16 good comparisons (R5, R8)
    repeat (16) compare(0, 2);
    // oscillator leads, polarity 1 (R3)
    compare(3, 0);
    // polarity 0 swaps the mapping (R3)
    pol = 1'b0;
    @(negedge clk);
    compare(0, 2);
    compare(4, 1);
    // long pulse drops lock mid-comparison; turbo stays off (R6, R8)
    compare(0, 10);
    // coincident edges (R4)
    compare(5, 5);
    // restart re-arms turbo (R9)
    do_restart();
    // turbo disabled: programmed code (R11)
    ten  = 1'b0;
    code = 2'b01;
    push(cyc + 1, S_ISEL, 1, "R11");
    @(negedge clk);
    @(negedge clk);
    // narrower window: width equal to window fails, then relock (R5, R6, R9)
    win = 8'd3;
    @(negedge clk);
    compare(0, 3);
    repeat (16) compare(1, 0);
    compare(2, 0);
    repeat (6) @(negedge clk);
    report();
  end
endmodule